// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is a two-sided byte mailbox. It sits between a host I/O bus and the bus of an embedded microcontroller, and it follows the programming model of a PC keyboard controller. The host sees two byte ports. One is a data port (0x60). The other is a command port (0x64), which returns the status byte when read. The embedded side sees four byte addresses:

| Address | Use |
|---|---|
| 0x7FF1 | Keyboard data |
| 0x7FFA | Auxiliary (pointing device) data |
| 0x7FF2 | Status |
| 0x7FF3 | Control register holding the keyboard interrupt enable |

The host writes a byte into the input buffer, and a status bit records whether the byte came through the command port or the data port. The embedded side reads that byte, which frees the buffer. In the other direction, the embedded side places a byte into the single output buffer through one of two addresses. The address chosen decides which interrupt line tells the host that a byte is waiting. A host read of the data port drains the buffer and drops both interrupt lines.

Three status bits belong to the hardware and cannot be written by the embedded side: the output-full flag, the input-full flag and the command/data flag. The other status bits are free for firmware, and bit 5 also records whether the last output byte came from the auxiliary path. When the two sides touch the flags in the same cycle, the host side wins.

Top module: `kbc_mailbox`

## Requirements
- R1: An embedded write to 0x7FF1 does the following:
  - loads the output buffer;
  - sets status bit 0 (output full) and clears status bit 5 (auxiliary source);
  - drives `kbd_irq` high from the next cycle when the enable bit (bit 0 of 0x7FF3) is 1.
- R2: An embedded write to 0x7FFA loads the output buffer, sets status bits 0 and 5, and drives `aux_irq` high from the next cycle. This path has no enable.
- R3: A host write to either port stores the byte in the input buffer and sets status bit 1 (input full). Status bit 3 (command/data) becomes 1 for port 0x64 and 0 for port 0x60.
- R4: An embedded read of 0x7FF1 returns the input buffer in the same cycle and clears status bit 1 from the next cycle.
- R5: A host read of port 0x60 returns the output buffer in the same cycle. From the next cycle, status bit 0 is clear and both `kbd_irq` and `aux_irq` are low. Status bit 5 is left as it was.
- R6: A host read of port 0x64 returns the full 8-bit status byte and changes no state.
- R7: An embedded write to 0x7FF2 replaces status bits 2, 4, 5, 6 and 7 and leaves bits 0, 1 and 3 unchanged. An embedded read of 0x7FF2 returns the same status byte the host sees.
- R8: Bit 0 of 0x7FF3 enables `kbd_irq`. It reads back at 0x7FF3 with the upper bits as 0. While it is 0:
  - `kbd_irq` is low, even if a keyboard byte is pending;
  - status bit 0 still sets on a 0x7FF1 write.
- R9: Only the path that loaded the byte currently waiting may hold its interrupt. A write to 0x7FF1 drops `aux_irq`, and a write to 0x7FFA drops `kbd_irq`.
- R10: When both sides act in the same cycle, the host side wins on the flags:
  - A host data read together with an embedded data write leaves status bit 0 and both interrupts clear. The new byte is still stored, and the host receives the old byte.
  - A host write together with an embedded read of 0x7FF1 leaves status bit 1 set. The embedded side receives the old byte, and the new byte is stored.
- R11: After reset, all of the following are 0 and `kbd_irq` and `aux_irq` are low:
  - the status byte;
  - both buffers;
  - the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_wr | input | 1 | Host write strobe, one cycle per access |
| h_rd | input | 1 | Host read strobe, one cycle per access |
| h_addr | input | 8 | Host port address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, valid while `h_rd` is high |
| e_wr | input | 1 | Embedded write strobe |
| e_rd | input | 1 | Embedded read strobe |
| e_addr | input | 16 | Embedded address |
| e_wdata | input | 8 | Embedded write data |
| e_rdata | output | 8 | Embedded read data, valid while `e_rd` is high |
| kbd_irq | output | 1 | Keyboard byte waiting for the host |
| aux_irq | output | 1 | Auxiliary byte waiting for the host |

## Verification
The properties are checked on every cycle:
- each flag takes its new value one cycle after the event that sets or clears it;
- the three hardware-owned status bits survive an embedded status write;
- `kbd_irq` is low whenever the enable bit is 0;
- the two interrupt lines are never high together;
- the host side wins when both sides act at once.

Other behaviour can only be shown by the bench's scenarios. These are:
- the byte values that actually cross the mailbox;
- the read-back of the status and control registers;
- the old byte returned during a collision while the new byte is kept;
- the sequences in which status bit 5 follows the source of the last output byte.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

  localparam int unsigned KBC_DW = 8;
  typedef logic [KBC_DW-1:0] kbc_byte_t;

  // status bit positions decoded by host software
  localparam int unsigned ST_OBF = 0;
  localparam int unsigned ST_IBF = 1;
  localparam int unsigned ST_CD  = 3;
  localparam int unsigned ST_AUX = 5;

  // bits the embedded side may not write
  localparam kbc_byte_t ST_HW_MASK =
    kbc_byte_t'((1 << ST_OBF) | (1 << ST_IBF) | (1 << ST_CD));

  typedef struct packed {
    logic wr_data;
    logic wr_cmd;
    logic rd_data;
    logic rd_stat;
  } host_ev_t;

  typedef struct packed {
    logic wr_kbd;
    logic wr_aux;
    logic wr_stat;
    logic wr_ctrl;
    logic rd_in;
    logic rd_stat;
    logic rd_ctrl;
  } ec_ev_t;

  // merge an embedded status write with the protected hardware bits
  function automatic kbc_byte_t stat_ec_merge(kbc_byte_t cur, kbc_byte_t wd);
    return (cur & ST_HW_MASK) | (wd & ~ST_HW_MASK);
  endfunction

  // control register image as seen on a read
  function automatic kbc_byte_t ctrl_image(logic en);
    return {{(KBC_DW-1){1'b0}}, en};
  endfunction

endpackage

// File: rtl/kbc_host_dec.sv
module kbc_host_dec
  import kbc_pkg::*;
#(
  parameter int unsigned HAW       = 8,
  parameter logic [HAW-1:0] DATA_PORT = 8'h60,
  parameter logic [HAW-1:0] CMD_PORT  = 8'h64
) (
  input  logic           h_wr,
  input  logic           h_rd,
  input  logic [HAW-1:0] h_addr,
  output host_ev_t       ev
);

  logic hit_data;
  logic hit_cmd;

  assign hit_data = (h_addr == DATA_PORT);
  assign hit_cmd  = (h_addr == CMD_PORT);

  always_comb begin
    ev.wr_data = h_wr & hit_data;
    ev.wr_cmd  = h_wr & hit_cmd;
    ev.rd_data = h_rd & hit_data;
    ev.rd_stat = h_rd & hit_cmd;
  end

endmodule

// File: rtl/kbc_ec_dec.sv
module kbc_ec_dec
  import kbc_pkg::*;
#(
  parameter int unsigned    EAW    = 16,
  parameter logic [EAW-1:0] A_KBD  = 16'h7FF1,
  parameter logic [EAW-1:0] A_STAT = 16'h7FF2,
  parameter logic [EAW-1:0] A_CTRL = 16'h7FF3,
  parameter logic [EAW-1:0] A_AUX  = 16'h7FFA
) (
  input  logic           e_wr,
  input  logic           e_rd,
  input  logic [EAW-1:0] e_addr,
  output ec_ev_t         ev
);

  logic hit_kbd, hit_aux, hit_stat, hit_ctrl;

  assign hit_kbd  = (e_addr == A_KBD);
  assign hit_aux  = (e_addr == A_AUX);
  assign hit_stat = (e_addr == A_STAT);
  assign hit_ctrl = (e_addr == A_CTRL);

  always_comb begin
    ev.wr_kbd  = e_wr & hit_kbd;
    ev.wr_aux  = e_wr & hit_aux;
    ev.wr_stat = e_wr & hit_stat;
    ev.wr_ctrl = e_wr & hit_ctrl;
    ev.rd_in   = e_rd & hit_kbd;
    ev.rd_stat = e_rd & hit_stat;
    ev.rd_ctrl = e_rd & hit_ctrl;
  end

endmodule

// File: rtl/kbc_flags.sv
module kbc_flags
  import kbc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  // host events
  input  logic      h_wr_data,
  input  logic      h_wr_cmd,
  input  logic      h_rd_data,
  input  logic      h_rd_stat,
  // embedded events
  input  logic      e_wr_kbd,
  input  logic      e_wr_aux,
  input  logic      e_wr_stat,
  input  logic      e_wr_ctrl,
  input  logic      e_rd_in,
  input  kbc_byte_t e_wdata,
  output kbc_byte_t stat_q,
  output logic      kbd_en,
  output logic      kbd_irq,
  output logic      aux_irq
);

  // named internal events, used by the assertions below
  logic host_wr_any;
  logic obf_set_ev;
  logic obf_clr_ev;
  logic ibf_clr_ev;

  assign host_wr_any = h_wr_data | h_wr_cmd;
  assign obf_set_ev  = e_wr_kbd | e_wr_aux;
  assign obf_clr_ev  = h_rd_data;
  assign ibf_clr_ev  = e_rd_in;

  kbc_byte_t stat_nxt;
  logic      kpend_q, kpend_nxt;
  logic      apend_q, apend_nxt;
  logic      en_q;

  always_comb begin
    stat_nxt  = stat_q;
    kpend_nxt = kpend_q;
    apend_nxt = apend_q;
    // embedded side first
    if (e_wr_stat) stat_nxt = stat_ec_merge(stat_q, e_wdata);
    if (e_wr_kbd) begin
      stat_nxt[ST_OBF] = 1'b1;
      stat_nxt[ST_AUX] = 1'b0;
      kpend_nxt        = en_q;
      apend_nxt        = 1'b0;
    end
    if (e_wr_aux) begin
      stat_nxt[ST_OBF] = 1'b1;
      stat_nxt[ST_AUX] = 1'b1;
      apend_nxt        = 1'b1;
      kpend_nxt        = 1'b0;
    end
    if (ibf_clr_ev) stat_nxt[ST_IBF] = 1'b0;
    // host side last, so it wins
    if (host_wr_any) begin
      stat_nxt[ST_IBF] = 1'b1;
      stat_nxt[ST_CD]  = h_wr_cmd;
    end
    if (obf_clr_ev) begin
      stat_nxt[ST_OBF] = 1'b0;
      kpend_nxt        = 1'b0;
      apend_nxt        = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      kpend_q <= 1'b0;
      apend_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      stat_q  <= stat_nxt;
      kpend_q <= kpend_nxt;
      apend_q <= apend_nxt;
      if (e_wr_ctrl) en_q <= e_wdata[0];
    end
  end

  assign kbd_en  = en_q;
  assign kbd_irq = kpend_q & en_q;
  assign aux_irq = apend_q;

  assert_obf_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    e_wr_kbd && !obf_clr_ev |=> stat_q[ST_OBF] && !stat_q[ST_AUX]);

  assert_kirq_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    e_wr_kbd && kbd_en && !obf_clr_ev |=> kbd_irq);

  assert_aux_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    e_wr_aux && !obf_clr_ev |=> aux_irq && stat_q[ST_OBF] && stat_q[ST_AUX]);

  assert_cmd_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    h_wr_cmd |=> stat_q[ST_IBF] && stat_q[ST_CD]);

  assert_data_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    h_wr_data |=> stat_q[ST_IBF] && !stat_q[ST_CD]);

  assert_ibf_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ibf_clr_ev && !host_wr_any |=> !stat_q[ST_IBF]);

  assert_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    obf_clr_ev |=> !stat_q[ST_OBF] && !kbd_irq && !aux_irq);

  assert_stat_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    h_rd_stat && !host_wr_any && !obf_clr_ev && !obf_set_ev && !e_wr_stat
    && !ibf_clr_ev |=> $stable(stat_q));

  assert_protect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    e_wr_stat && !host_wr_any && !obf_clr_ev
    |=> ((stat_q & ST_HW_MASK) == ($past(stat_q) & ST_HW_MASK))
     && ((stat_q & ~ST_HW_MASK) == ($past(e_wdata) & ~ST_HW_MASK)));

  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !kbd_en |-> !kbd_irq);

  assert_single_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({kbd_irq, aux_irq}));

  assert_ibf_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_any && ibf_clr_ev |=> stat_q[ST_IBF]);

  assert_obf_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
    obf_clr_ev && obf_set_ev |=> !stat_q[ST_OBF] && !kbd_irq && !aux_irq);

endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox
  import kbc_pkg::*;
#(
  parameter int unsigned    HAW       = 8,
  parameter int unsigned    EAW       = 16,
  parameter logic [HAW-1:0] DATA_PORT = 8'h60,
  parameter logic [HAW-1:0] CMD_PORT  = 8'h64,
  parameter logic [EAW-1:0] A_KBD     = 16'h7FF1,
  parameter logic [EAW-1:0] A_STAT    = 16'h7FF2,
  parameter logic [EAW-1:0] A_CTRL    = 16'h7FF3,
  parameter logic [EAW-1:0] A_AUX     = 16'h7FFA
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           h_wr,
  input  logic           h_rd,
  input  logic [HAW-1:0] h_addr,
  input  logic [7:0]     h_wdata,
  output logic [7:0]     h_rdata,
  input  logic           e_wr,
  input  logic           e_rd,
  input  logic [EAW-1:0] e_addr,
  input  logic [7:0]     e_wdata,
  output logic [7:0]     e_rdata,
  output logic           kbd_irq,
  output logic           aux_irq
);

  host_ev_t  hev;
  ec_ev_t    eev;
  kbc_byte_t stat_q;
  kbc_byte_t obuf_q;
  kbc_byte_t ibuf_q;
  logic      kbd_en;
  logic      host_load;
  logic      ec_load;

  kbc_host_dec #(
    .HAW(HAW), .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)
  ) u_hdec (
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .ev(hev)
  );

  kbc_ec_dec #(
    .EAW(EAW), .A_KBD(A_KBD), .A_STAT(A_STAT), .A_CTRL(A_CTRL), .A_AUX(A_AUX)
  ) u_edec (
    .e_wr(e_wr), .e_rd(e_rd), .e_addr(e_addr), .ev(eev)
  );

  kbc_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_wr_data (hev.wr_data),
    .h_wr_cmd  (hev.wr_cmd),
    .h_rd_data (hev.rd_data),
    .h_rd_stat (hev.rd_stat),
    .e_wr_kbd  (eev.wr_kbd),
    .e_wr_aux  (eev.wr_aux),
    .e_wr_stat (eev.wr_stat),
    .e_wr_ctrl (eev.wr_ctrl),
    .e_rd_in   (eev.rd_in),
    .e_wdata   (e_wdata),
    .stat_q    (stat_q),
    .kbd_en    (kbd_en),
    .kbd_irq   (kbd_irq),
    .aux_irq   (aux_irq)
  );

  assign host_load = hev.wr_data | hev.wr_cmd;
  assign ec_load   = eev.wr_kbd | eev.wr_aux;

  // shared byte buffers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obuf_q <= '0;
      ibuf_q <= '0;
    end else begin
      if (ec_load)   obuf_q <= e_wdata;
      if (host_load) ibuf_q <= h_wdata;
    end
  end

  // read multiplexers, combinational within the strobe cycle
  always_comb begin
    h_rdata = '0;
    if (hev.rd_data)      h_rdata = obuf_q;
    else if (hev.rd_stat) h_rdata = stat_q;
  end

  always_comb begin
    e_rdata = '0;
    if (eev.rd_in)        e_rdata = ibuf_q;
    else if (eev.rd_stat) e_rdata = stat_q;
    else if (eev.rd_ctrl) e_rdata = ctrl_image(kbd_en);
  end

  assert_obuf_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ec_load |=> obuf_q == $past(e_wdata));

  assert_ibuf_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_load |=> ibuf_q == $past(h_wdata));

  assert_drain_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hev.rd_data |-> h_rdata == obuf_q);

  assert_same_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eev.rd_stat && hev.rd_stat |-> e_rdata == h_rdata);

endmodule

// File: tb/kbc_mailbox_test.sv
`timescale 1ns/1ps
module kbc_mailbox_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        h_wr, h_rd;
  logic [7:0]  h_addr, h_wdata, h_rdata;
  logic        e_wr, e_rd;
  logic [15:0] e_addr;
  logic [7:0]  e_wdata, e_rdata;
  logic        kbd_irq, aux_irq;

  always #2 clk = ~clk;

  kbc_mailbox uut (
    .clk(clk), .rst_n(rst_n),
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .e_wr(e_wr), .e_rd(e_rd), .e_addr(e_addr), .e_wdata(e_wdata), .e_rdata(e_rdata),
    .kbd_irq(kbd_irq), .aux_irq(aux_irq)
  );

  localparam logic [7:0]  P_DATA = 8'h60, P_CMD = 8'h64;
  localparam logic [15:0] E_KBD = 16'h7FF1, E_STAT = 16'h7FF2,
                          E_CTRL = 16'h7FF3, E_AUX = 16'h7FFA;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    bit        ec_side;
    logic [7:0] val;
    string     tag;
  } exp_t;
  exp_t sb[$];

  // bench model, built from the requirements
  logic [7:0] m_stat, m_obuf, m_ibuf;
  logic       m_en, m_kp, m_ap;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_pins(string tag);
    check({tag, " kbd_irq"}, {7'b0, kbd_irq}, {7'b0, m_kp & m_en});
    check({tag, " aux_irq"}, {7'b0, aux_irq}, {7'b0, m_ap});
  endtask

  function automatic logic [7:0] m_ec_read(logic [15:0] a);
    if (a == E_KBD)  return m_ibuf;
    if (a == E_STAT) return m_stat;
    if (a == E_CTRL) return {7'b0, m_en};
    return 8'h00;
  endfunction

  task automatic m_ec_wr(logic [15:0] a, logic [7:0] d);
    if (a == E_KBD) begin
      m_obuf = d; m_stat[0] = 1'b1; m_stat[5] = 1'b0; m_kp = m_en; m_ap = 1'b0;
    end else if (a == E_AUX) begin
      m_obuf = d; m_stat[0] = 1'b1; m_stat[5] = 1'b1; m_ap = 1'b1; m_kp = 1'b0;
    end else if (a == E_STAT) begin
      m_stat = (m_stat & 8'b0000_1011) | (d & 8'b1111_0100);
    end else if (a == E_CTRL) begin
      m_en = d[0];
    end
  endtask

  task automatic m_h_wr(logic [7:0] p, logic [7:0] d);
    m_ibuf = d; m_stat[1] = 1'b1; m_stat[3] = (p == P_CMD);
  endtask

  task automatic m_h_rd(logic [7:0] p);
    if (p == P_DATA) begin
      m_stat[0] = 1'b0; m_kp = 1'b0; m_ap = 1'b0;
    end
  endtask

  // driver tasks
  task automatic ec_write(logic [15:0] a, logic [7:0] d);
    @(posedge clk); #1;
    e_wr = 1'b1; e_addr = a; e_wdata = d;
    @(posedge clk); #1;
    e_wr = 1'b0;
    m_ec_wr(a, d);
  endtask

  task automatic ec_read(logic [15:0] a, string tag);
    exp_t it;
    @(posedge clk); #1;
    it.ec_side = 1'b1; it.val = m_ec_read(a); it.tag = tag;
    sb.push_back(it);
    e_rd = 1'b1; e_addr = a;
    @(posedge clk); #1;
    e_rd = 1'b0;
    if (a == E_KBD) m_stat[1] = 1'b0;
  endtask

  task automatic host_write(logic [7:0] p, logic [7:0] d);
    @(posedge clk); #1;
    h_wr = 1'b1; h_addr = p; h_wdata = d;
    @(posedge clk); #1;
    h_wr = 1'b0;
    m_h_wr(p, d);
  endtask

  task automatic host_read(logic [7:0] p, string tag);
    exp_t it;
    @(posedge clk); #1;
    it.ec_side = 1'b0; it.val = (p == P_DATA) ? m_obuf : m_stat; it.tag = tag;
    sb.push_back(it);
    h_rd = 1'b1; h_addr = p;
    @(posedge clk); #1;
    h_rd = 1'b0;
    m_h_rd(p);
  endtask

  // host data read colliding with an embedded data write
  task automatic clash_drain(logic [15:0] a, logic [7:0] d, string tag);
    exp_t it;
    @(posedge clk); #1;
    it.ec_side = 1'b0; it.val = m_obuf; it.tag = tag;
    sb.push_back(it);
    h_rd = 1'b1; h_addr = P_DATA;
    e_wr = 1'b1; e_addr = a; e_wdata = d;
    @(posedge clk); #1;
    h_rd = 1'b0; e_wr = 1'b0;
    m_ec_wr(a, d);
    m_h_rd(P_DATA);
  endtask

  // host write colliding with an embedded input read
  task automatic clash_fill(logic [7:0] p, logic [7:0] d, string tag);
    exp_t it;
    @(posedge clk); #1;
    it.ec_side = 1'b1; it.val = m_ibuf; it.tag = tag;
    sb.push_back(it);
    e_rd = 1'b1; e_addr = E_KBD;
    h_wr = 1'b1; h_addr = p; h_wdata = d;
    @(posedge clk); #1;
    e_rd = 1'b0; h_wr = 1'b0;
    m_stat[1] = 1'b0;
    m_h_wr(p, d);
  endtask

  // monitor: pops expected read data and compares mid-cycle
  always @(negedge clk) begin
    if (h_rd || e_rd) begin
      if (sb.size() == 0) begin
        check("scoreboard underflow", 8'h01, 8'h00);
      end else begin
        exp_t it;
        it = sb.pop_front();
        check(it.tag, it.ec_side ? e_rdata : h_rdata, it.val);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    h_wr = 0; h_rd = 0; h_addr = 0; h_wdata = 0;
    e_wr = 0; e_rd = 0; e_addr = 0; e_wdata = 0;
    m_stat = 0; m_obuf = 0; m_ibuf = 0; m_en = 0; m_kp = 0; m_ap = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11: reset state
    check_pins("R11 reset");
    host_read(P_CMD, "R11 reset status");
    ec_read(E_CTRL, "R11 reset enable");
    host_read(P_DATA, "R11 reset output buffer");
    ec_read(E_KBD, "R11 reset input buffer");

    // R8: keyboard byte with enable off still sets OBF, no interrupt
    ec_write(E_KBD, 8'hA5);
    check_pins("R8 disabled kbd write");
    host_read(P_CMD, "R8 status with enable off");
    host_read(P_DATA, "R5 drain A5");
    host_read(P_CMD, "R5 status after drain");
    check_pins("R5 after drain");

    // R1: enable on, keyboard write raises kbd_irq
    ec_write(E_CTRL, 8'hFF);
    ec_read(E_CTRL, "R8 enable readback");
    ec_write(E_KBD, 8'h3C);
    check_pins("R1 kbd write");
    host_read(P_CMD, "R1 status after kbd write");

    // R2/R9: aux write takes over the buffer and the interrupt
    ec_write(E_AUX, 8'h77);
    check_pins("R9 aux replaces kbd");
    host_read(P_CMD, "R2 status after aux write");
    host_read(P_DATA, "R2 aux byte");
    host_read(P_CMD, "R5 aux tag kept after drain");
    check_pins("R5 aux drained");

    // R9: keyboard write clears aux tag and takes over
    ec_write(E_AUX, 8'h12);
    ec_write(E_KBD, 8'h11);
    check_pins("R9 kbd replaces aux");
    host_read(P_CMD, "R1 aux tag cleared");
    host_read(P_DATA, "R1 kbd byte 11");

    // R3/R4: host data and command writes
    host_write(P_DATA, 8'h5A);
    host_read(P_CMD, "R3 data write flags");
    ec_read(E_KBD, "R4 data byte");
    host_read(P_CMD, "R4 IBF cleared");
    host_write(P_CMD, 8'hD4);
    host_read(P_CMD, "R3 command write flags");
    ec_read(E_STAT, "R7 embedded status read");
    ec_read(E_KBD, "R4 command byte");

    // R7: protected status bits
    ec_write(E_STAT, 8'hFF);
    host_read(P_CMD, "R7 status write all ones");
    ec_write(E_STAT, 8'h00);
    host_read(P_CMD, "R7 status write zeros");
    host_write(P_DATA, 8'h01);
    ec_write(E_KBD, 8'h02);
    ec_write(E_STAT, 8'h00);
    host_read(P_CMD, "R7 flags kept over write");
    ec_read(E_STAT, "R6 R7 status both sides");
    host_read(P_CMD, "R6 repeat status read");

    // R10: collisions
    clash_drain(E_KBD, 8'h99, "R10 host gets old byte");
    check_pins("R10 drain wins");
    host_read(P_CMD, "R10 OBF clear after clash");
    host_read(P_DATA, "R10 new byte stored");
    clash_fill(P_DATA, 8'h44, "R10 embedded gets old byte");
    host_read(P_CMD, "R10 IBF kept after clash");
    ec_read(E_KBD, "R10 new input byte stored");

    // R8: dropping enable gates a pending keyboard interrupt
    ec_write(E_KBD, 8'h55);
    check_pins("R1 kbd pending");
    ec_write(E_CTRL, 8'h00);
    check_pins("R8 gated after disable");
    ec_read(E_CTRL, "R8 enable cleared readback");
    host_read(P_DATA, "R5 drain 55");
    check_pins("R5 final");

    repeat (2) @(posedge clk);
    check("scoreboard empty", 8'(sb.size()), 8'h00);
    finish_run();
  end

endmodule